// File: doc/BRIEF.md
# Sub-word Register Access Bridge

This bridge lets a host that issues byte, halfword and word register accesses work with a peripheral register file that only accepts aligned 32-bit reads and writes. A narrow read fetches the containing word and returns the addressed lane, zero-extended. A narrow write reads the containing word, replaces one lane and writes the full word back. The bridge handles one access at a time and stalls the host until that access is finished.

One register pair needs special handling. It is a 16-bit transfer-setup half in the low lane and a 16-bit command half in the high lane of the same word. A halfword write to the setup half is kept in a local shadow word and is not sent downstream. The next halfword write to the command half takes the setup half from the shadow, so both halves reach the peripheral in a single 32-bit write. The peripheral can lose a write that arrives too soon after the previous one. For that reason, each downstream write is held back until a programmable number of system clock cycles has passed since the last write. Reads are never held back.

Top module: `subword_bridge`

## Requirements
- R1: After reset, `upReady` is 1 and `dnValid` and `rspValid` are 0. The shadow word is zero, so a command-half write made before any setup-half write carries 16'h0000 in its low lane.
- R2: Every downstream access uses the requested byte offset with bits 1:0 forced to zero.
- R3: `upSize` encodes 0 as byte, 1 as halfword, and 2 or 3 as word. A read returns a byte from lane `upAddr[1:0]` (bits 8*lane+7 down to 8*lane), a halfword from lane `upAddr[1]` (bits 15:0 or 31:16), or the whole word. Narrow results are zero-extended on `rspData`.
- R4: A read issues its downstream read in the cycle after the accept cycle and raises `rspValid` in the cycle after that, whatever write spacing is still pending.
- R5: A byte or halfword write outside the shadowed pair makes exactly one downstream read and then one downstream write. The written word keeps every lane it does not address and takes the new lane from the low 8 or 16 bits of `upWdata`.
- R6: A word write makes exactly one downstream write of `upWdata` and no downstream read.
- R7: A halfword write to offset `XFER_OFS` (or `XFER_OFS`+1) makes no downstream access. It replaces the low half of the shadow word.
- R8: A halfword write to offset `XFER_OFS`+2 (or +3) makes no downstream read. It makes one write of {new 16 bits, shadow low half} and leaves the shadow unchanged.
- R9: A word write to the word at `XFER_OFS` also loads the whole written value into the shadow word.
- R10: If two downstream writes are strobed in cycles t1 < t2, then t2 - t1 is at least `cfgGap`, and at least 1.
- R11: `upReady` is 0 from the accept until `rspValid`. Every accepted access produces exactly one `rspValid` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgGap | input | GAP_W | Minimum cycles between downstream write strobes |
| upValid | input | 1 | Host request valid |
| upReady | output | 1 | Bridge can accept a request |
| upWrite | input | 1 | 1 = write, 0 = read |
| upSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| upAddr | input | ADDR_W | Byte offset of the access |
| upWdata | input | 32 | Write value, right-aligned for narrow sizes |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | 32 | Read result, zero-extended lane |
| dnValid | output | 1 | Downstream access strobe |
| dnWrite | output | 1 | Downstream access is a write |
| dnAddr | output | ADDR_W | Word-aligned downstream byte address |
| dnWdata | output | 32 | Downstream write word |
| dnRdata | input | 32 | Downstream read word, valid in the same cycle as the strobe |

## Verification
The bench sends a command-half write straight after reset. A bridge whose shadow did not start at zero would leave leftover data in the low lane. The bench then writes the setup half and checks that the peripheral word does not change: a bridge that forwarded it would write through at once. Command writes are repeated, and a shadow that was updated by the command path would change their low lanes. Word writes to the shared word must reload the shadow. Byte and halfword writes are checked for lane placement against a mirror of the peripheral, which exposes shift errors and mask errors. Back-to-back writes and write-then-read pairs are run under several gap settings. A bridge that skipped the spacing wait would strobe writes too close together, and one that applied the wait to reads would deliver read data late.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    CL_READ,
    CL_RMW,
    CL_FULL,
    CL_XFER,
    CL_CMD
  } reqClass_e;

  typedef struct packed {
    logic load;
    logic rdLatch;
    logic rmwMerge;
  } ctrlStrobe_t;

  function automatic logic [WORD_W-1:0] laneGet(input logic [WORD_W-1:0] word,
                                                input logic [1:0] size,
                                                input logic [1:0] ofs);
    case (size)
      2'd0:    return (word >> {ofs, 3'b000}) & 32'h0000_00ff;
      2'd1:    return ofs[1] ? {16'h0000, word[31:16]} : {16'h0000, word[15:0]};
      default: return word;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] laneSet(input logic [WORD_W-1:0] old,
                                                input logic [WORD_W-1:0] val,
                                                input logic [1:0] size,
                                                input logic [1:0] ofs);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] ins;
    case (size)
      2'd0: begin
        mask = 32'h0000_00ff << {ofs, 3'b000};
        ins  = {24'h000000, val[7:0]} << {ofs, 3'b000};
      end
      2'd1: begin
        mask = ofs[1] ? 32'hffff_0000 : 32'h0000_ffff;
        ins  = ofs[1] ? {val[15:0], 16'h0000} : {16'h0000, val[15:0]};
      end
      default: begin
        mask = '1;
        ins  = val;
      end
    endcase
    return (old & ~mask) | ins;
  endfunction

endpackage

// File: rtl/sbr_datapath.sv
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] XFER_OFS = 'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              upWrite,
  input  logic [1:0]        upSize,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [WORD_W-1:0] upWdata,
  output reqClass_e         reqClass,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [WORD_W-1:0] dnWdata,
  input  logic [WORD_W-1:0] dnRdata,
  output logic [WORD_W-1:0] rspData
);

  localparam logic [ADDR_W-1:0] CMD_OFS = XFER_OFS + ADDR_W'(2);

  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic [WORD_W-1:0] reqWdata;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] shadowReg;
  logic [WORD_W-1:0] rspReg;

  logic isHalf;
  logic hitXfer;
  logic hitCmd;
  logic hitXferWord;

  assign isHalf      = (upSize == SZ_HALF);
  assign hitXfer     = (upAddr[ADDR_W-1:1] == XFER_OFS[ADDR_W-1:1]);
  assign hitCmd      = (upAddr[ADDR_W-1:1] == CMD_OFS[ADDR_W-1:1]);
  assign hitXferWord = (upAddr[ADDR_W-1:2] == XFER_OFS[ADDR_W-1:2]);

  always_comb begin
    if (!upWrite)               reqClass = CL_READ;
    else if (isHalf && hitXfer) reqClass = CL_XFER;
    else if (isHalf && hitCmd)  reqClass = CL_CMD;
    else if (upSize[1])         reqClass = CL_FULL;
    else                        reqClass = CL_RMW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr   <= '0;
      reqSize   <= '0;
      reqWdata  <= '0;
      wordReg   <= '0;
      shadowReg <= '0;
      rspReg    <= '0;
    end else begin
      if (strobe.load) begin
        reqAddr  <= upAddr;
        reqSize  <= upSize;
        reqWdata <= upWdata;
        case (reqClass)
          CL_FULL: begin
            wordReg <= upWdata;
            if (hitXferWord) shadowReg <= upWdata;
          end
          CL_CMD:  wordReg   <= laneSet(shadowReg, upWdata, SZ_HALF, upAddr[1:0]);
          CL_XFER: shadowReg <= laneSet(shadowReg, upWdata, SZ_HALF, upAddr[1:0]);
          default: ;
        endcase
      end
      if (strobe.rmwMerge) wordReg <= laneSet(dnRdata, reqWdata, reqSize, reqAddr[1:0]);
      if (strobe.rdLatch)  rspReg  <= laneGet(dnRdata, reqSize, reqAddr[1:0]);
    end
  end

  assign dnAddr  = {reqAddr[ADDR_W-1:2], 2'b00};
  assign dnWdata = wordReg;
  assign rspData = rspReg;

  // R8: the command path reads the shadow but never rewrites it
  p_cmd_keeps_shadow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqClass == CL_CMD) |=> $stable(shadowReg))
    else $error("command half write altered the shadow word");

  // R9: a word write to the shared word becomes the new shadow
  p_word_loads_shadow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqClass == CL_FULL && hitXferWord) |=> (shadowReg == reqWdata))
    else $error("shared word write did not reload the shadow");

endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GAP_W-1:0] cfgGap,
  input  logic             upValid,
  input  reqClass_e        reqClass,
  output logic             upReady,
  output logic             dnValid,
  output logic             dnWrite,
  output logic             rspValid,
  output ctrlStrobe_t      strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RMW,
    ST_WR,
    ST_RSP
  } state_e;

  state_e           state;
  state_e           stateNext;
  logic [GAP_W-1:0] gapCnt;
  logic             gapOpen;
  logic             accept;
  logic             wrIssue;

  assign gapOpen = (gapCnt == '0);
  assign accept  = upValid && (state == ST_IDLE);
  assign wrIssue = (state == ST_WR) && gapOpen;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) begin
        case (reqClass)
          CL_READ:        stateNext = ST_RD;
          CL_RMW:         stateNext = ST_RMW;
          CL_XFER:        stateNext = ST_RSP;
          default:        stateNext = ST_WR;
        endcase
      end
      ST_RD:   stateNext = ST_RSP;
      ST_RMW:  stateNext = ST_WR;
      ST_WR:   if (gapOpen) stateNext = ST_RSP;
      ST_RSP:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= stateNext;
      if (wrIssue)      gapCnt <= (cfgGap == '0) ? '0 : cfgGap - 1'b1;
      else if (!gapOpen) gapCnt <= gapCnt - 1'b1;
    end
  end

  assign upReady         = (state == ST_IDLE);
  assign dnValid         = (state == ST_RD) || (state == ST_RMW) || wrIssue;
  assign dnWrite         = (state == ST_WR);
  assign rspValid        = (state == ST_RSP);
  assign strobe.load     = accept;
  assign strobe.rdLatch  = (state == ST_RD);
  assign strobe.rmwMerge = (state == ST_RMW);

  // Independent spacing monitor: cycles since the last write strobe
  logic [GAP_W:0]   sinceWr;
  logic [GAP_W-1:0] lastGap;
  logic             seenWr;
  logic [GAP_W:0]   minSpace;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceWr <= '0;
      lastGap <= '0;
      seenWr  <= 1'b0;
    end else if (dnValid && dnWrite) begin
      sinceWr <= 1;
      lastGap <= cfgGap;
      seenWr  <= 1'b1;
    end else if (sinceWr != '1) begin
      sinceWr <= sinceWr + 1'b1;
    end
  end

  assign minSpace = (lastGap == '0) ? 1 : {1'b0, lastGap};

  p_gap_kept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnWrite && seenWr) |-> (sinceWr >= minSpace))
    else $error("downstream writes closer than the programmed gap");

  p_read_prompt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upReady && reqClass == CL_READ) |=> (dnValid && !dnWrite))
    else $error("read was not issued in the cycle after accept");

  p_xfer_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upReady && reqClass == CL_XFER) |=> !dnValid)
    else $error("setup half write reached the peripheral");

  p_single_rsp_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && upReady))
    else $error("response pulse longer than one cycle");

endmodule

// File: rtl/subword_bridge.sv
module subword_bridge
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int GAP_W  = 8,
  parameter logic [ADDR_W-1:0] XFER_OFS = 'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GAP_W-1:0]  cfgGap,
  input  logic              upValid,
  output logic              upReady,
  input  logic              upWrite,
  input  logic [1:0]        upSize,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [31:0]       upWdata,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              dnValid,
  output logic              dnWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [31:0]       dnWdata,
  input  logic [31:0]       dnRdata
);

  ctrlStrobe_t strobe;
  reqClass_e   reqClass;

  sbr_ctrl #(.GAP_W(GAP_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgGap   (cfgGap),
    .upValid  (upValid),
    .reqClass (reqClass),
    .upReady  (upReady),
    .dnValid  (dnValid),
    .dnWrite  (dnWrite),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  sbr_datapath #(.ADDR_W(ADDR_W), .XFER_OFS(XFER_OFS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .upWrite  (upWrite),
    .upSize   (upSize),
    .upAddr   (upAddr),
    .upWdata  (upWdata),
    .reqClass (reqClass),
    .dnAddr   (dnAddr),
    .dnWdata  (dnWdata),
    .dnRdata  (dnRdata),
    .rspData  (rspData)
  );

endmodule

// File: tb/subword_bridge_tb.sv
module subword_bridge_tb_top;

  localparam int ADDR_W = 6;
  localparam int GAP_W  = 8;
  localparam logic [5:0] XFER = 6'h0C;
  localparam logic [5:0] CMD  = 6'h0E;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [GAP_W-1:0]  cfgGap = '0;
  logic              upValid = 1'b0;
  logic              upReady;
  logic              upWrite = 1'b0;
  logic [1:0]        upSize = 2'd0;
  logic [ADDR_W-1:0] upAddr = '0;
  logic [31:0]       upWdata = '0;
  logic              rspValid;
  logic [31:0]       rspData;
  logic              dnValid;
  logic              dnWrite;
  logic [ADDR_W-1:0] dnAddr;
  logic [31:0]       dnWdata;
  logic [31:0]       dnRdata;

  always #5 clk = ~clk;

  subword_bridge #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .XFER_OFS(XFER)) dut_i (
    .clk(clk), .rstN(rstN), .cfgGap(cfgGap),
    .upValid(upValid), .upReady(upReady), .upWrite(upWrite), .upSize(upSize),
    .upAddr(upAddr), .upWdata(upWdata), .rspValid(rspValid), .rspData(rspData),
    .dnValid(dnValid), .dnWrite(dnWrite), .dnAddr(dnAddr), .dnWdata(dnWdata),
    .dnRdata(dnRdata)
  );

  function automatic logic [31:0] seedWord(input int i);
    return (32'h0102_0304 * (i + 1)) ^ 32'hC3A5_9617;
  endfunction

  // Peripheral register file model
  logic [31:0] pmem [16];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) pmem[i] <= seedWord(i);
    end else if (dnValid && dnWrite) begin
      pmem[dnAddr[5:2]] <= dnWdata;
    end
  end
  assign dnRdata = pmem[dnAddr[5:2]];

  // Reference model state
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          lastWrCyc = -1;
  int          acceptCyc = 0;
  int          rdSeen = 0;
  int          wrSeen = 0;
  int          expRdN = 0;
  int          expWrN = 0;
  bit          pendRead = 0;
  bit          rspPending = 0;
  bit          done = 0;
  logic [31:0] mirror [16];
  logic [31:0] shadowM = '0;
  logic [31:0] expRsp = '0;
  logic [5:0]  expAddr = '0;
  logic [37:0] expWrQ [$];
  string       curTag = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pickLane(input logic [31:0] w, input logic [1:0] sz,
                                           input logic [1:0] o);
    if (sz == 2'd0) return (w >> (8 * o)) & 32'd255;
    if (sz == 2'd1) return (w >> (16 * (o / 2))) & 32'd65535;
    return w;
  endfunction

  function automatic logic [31:0] putLane(input logic [31:0] w, input logic [31:0] v,
                                          input logic [1:0] sz, input logic [1:0] o);
    logic [31:0] r;
    r = w;
    if (sz == 2'd0) begin
      for (int b = 0; b < 8; b++) r[8 * o + b] = v[b];
    end else if (sz == 2'd1) begin
      for (int b = 0; b < 16; b++) r[16 * (o / 2) + b] = v[b];
    end else begin
      r = v;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (dnValid && !dnWrite) begin
        rdSeen++;
        check(dnAddr == expAddr, "R2", "read address", {26'h0, dnAddr}, {26'h0, expAddr});
      end
      if (dnValid && dnWrite) begin
        int minGap;
        wrSeen++;
        minGap = (cfgGap == 0) ? 1 : int'(cfgGap);
        if (lastWrCyc >= 0)
          check(cyc - lastWrCyc >= minGap, "R10", "write spacing",
                32'(cyc - lastWrCyc), 32'(minGap));
        lastWrCyc = cyc;
        if (expWrQ.size() == 0) begin
          check(1'b0, "R7", "unexpected downstream write", dnWdata, 32'h0);
        end else begin
          logic [37:0] e;
          e = expWrQ.pop_front();
          check(dnAddr == e[37:32], "R2", "write address", {26'h0, dnAddr}, {26'h0, e[37:32]});
          check(dnWdata == e[31:0], curTag, "write data", dnWdata, e[31:0]);
        end
      end
      if (rspValid) begin
        check(rspPending, "R11", "response without request", 32'h1, 32'h0);
        check(!upReady, "R11", "ready during response", {31'h0, upReady}, 32'h0);
        rspPending = 0;
        check(rdSeen == expRdN, curTag, "downstream read count", 32'(rdSeen), 32'(expRdN));
        check(wrSeen == expWrN, curTag, "downstream write count", 32'(wrSeen), 32'(expWrN));
        if (pendRead) begin
          check(rspData == expRsp, "R3", "read data", rspData, expRsp);
          check(cyc == acceptCyc + 2, "R4", "read latency", 32'(cyc - acceptCyc), 32'd2);
          pendRead = 0;
        end
      end
      if (upValid && upReady) begin
        logic [3:0]  w;
        logic [31:0] word;
        check(!rspPending, "R11", "accept while busy", 32'h1, 32'h0);
        w = upAddr[5:2];
        expAddr = {upAddr[5:2], 2'b00};
        rdSeen = 0;
        wrSeen = 0;
        rspPending = 1;
        acceptCyc = cyc;
        if (!upWrite) begin
          expRsp = pickLane(mirror[w], upSize, upAddr[1:0]);
          pendRead = 1;
          expRdN = 1; expWrN = 0; curTag = "R3";
        end else if (upSize == 2'd1 && upAddr[5:1] == XFER[5:1]) begin
          shadowM = putLane(shadowM, upWdata, 2'd1, 2'd0);
          expRdN = 0; expWrN = 0; curTag = "R7";
        end else if (upSize == 2'd1 && upAddr[5:1] == CMD[5:1]) begin
          word = {upWdata[15:0], shadowM[15:0]};
          expWrQ.push_back({expAddr, word});
          mirror[w] = word;
          expRdN = 0; expWrN = 1; curTag = "R8";
        end else if (upSize[1]) begin
          word = upWdata;
          if (w == XFER[5:2]) begin
            shadowM = upWdata;
            curTag = "R9";
          end else begin
            curTag = "R6";
          end
          expWrQ.push_back({expAddr, word});
          mirror[w] = word;
          expRdN = 0; expWrN = 1;
        end else begin
          word = putLane(mirror[w], upWdata, upSize, upAddr[1:0]);
          expWrQ.push_back({expAddr, word});
          mirror[w] = word;
          expRdN = 1; expWrN = 1; curTag = "R5";
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [1:0] sz, input logic [5:0] a,
                        input logic [31:0] d);
    @(posedge clk); #1;
    upValid = 1'b1; upWrite = wr; upSize = sz; upAddr = a; upWdata = d;
    @(negedge clk);
    while (!upReady) @(negedge clk);
    @(posedge clk); #1;
    upValid = 1'b0;
    @(negedge clk);
    while (!rspValid) @(negedge clk);
  endtask

  task automatic setGap(input logic [GAP_W-1:0] g);
    repeat (40) @(posedge clk);
    #1 cfgGap = g;
  endtask

  logic [31:0] rng = 32'h2468_ACE1;
  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mirror[i] = seedWord(i);
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(upReady == 1'b1, "R1", "reset ready", {31'h0, upReady}, 32'h1);
    check(dnValid == 1'b0, "R1", "reset dnValid", {31'h0, dnValid}, 32'h0);
    check(rspValid == 1'b0, "R1", "reset rspValid", {31'h0, rspValid}, 32'h0);

    // Shadow starts at zero (R1), setup half is held (R7), command merges (R8)
    access(1, 2'd1, CMD, 32'h0000_ABCD);
    check(pmem[3] == 32'hABCD_0000, "R1", "shadow reset value", pmem[3], 32'hABCD_0000);
    access(1, 2'd1, XFER, 32'hFFFF_1234);
    check(pmem[3] == 32'hABCD_0000, "R7", "setup half not forwarded", pmem[3], 32'hABCD_0000);
    access(1, 2'd1, CMD, 32'h0000_5678);
    check(pmem[3] == 32'h5678_1234, "R8", "merged command word", pmem[3], 32'h5678_1234);
    access(1, 2'd1, CMD, 32'h0000_9999);
    check(pmem[3] == 32'h9999_1234, "R8", "shadow kept", pmem[3], 32'h9999_1234);
    access(1, 2'd2, XFER, 32'hDEAD_BEEF);
    access(1, 2'd1, CMD, 32'h0000_0001);
    check(pmem[3] == 32'h0001_BEEF, "R9", "word reloads shadow", pmem[3], 32'h0001_BEEF);

    // Lane placement for narrow writes (R5) and reads (R3)
    access(1, 2'd0, 6'h11, 32'hFFFF_FF5A);
    access(1, 2'd0, 6'h13, 32'h0000_00C7);
    access(1, 2'd1, 6'h14, 32'hAAAA_7E81);
    access(1, 2'd1, 6'h17, 32'h0000_3C3C);
    for (int o = 0; o < 4; o++) access(0, 2'd0, 6'h10 + 6'(o), 32'h0);
    access(0, 2'd1, 6'h12, 32'h0);
    access(0, 2'd1, 6'h15, 32'h0);
    access(0, 2'd3, 6'h16, 32'h0);

    // Write spacing (R10) and reads unaffected by it (R4)
    for (int g = 0; g < 3; g++) begin
      setGap((g == 0) ? 8'd7 : (g == 1) ? 8'd25 : 8'd1);
      access(1, 2'd2, 6'h20, 32'h1111_0000 + 32'(g));
      access(1, 2'd2, 6'h24, 32'h2222_0000 + 32'(g));
      access(0, 2'd2, 6'h20, 32'h0);
      access(1, 2'd0, 6'h2A, 32'h0000_0055);
      access(0, 2'd0, 6'h2A, 32'h0);
      access(1, 2'd1, CMD, 32'h0000_7777);
    end

    // Mixed traffic under several gaps
    for (int blk = 0; blk < 4; blk++) begin
      setGap((blk == 0) ? 8'd0 : (blk == 1) ? 8'd3 : (blk == 2) ? 8'd12 : 8'd2);
      for (int n = 0; n < 80; n++) begin
        logic [31:0] r;
        rng = nextRng(rng);
        r = rng;
        rng = nextRng(rng);
        access(r[0], r[2:1], r[8:3], rng);
      end
    end

    repeat (40) @(posedge clk);
    @(negedge clk);
    check(expWrQ.size() == 0, "R7", "writes left unissued", 32'(expWrQ.size()), 32'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule